// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block moves frames from system memory to a byte stream under the control of a ring of descriptors. Each descriptor occupies four 32-bit words. The word at offset 0 is the status/control word, the word at offset 4 is a tag word, and the words at offsets 8 and 12 hold the low and high halves of the frame buffer address. Software fills in a descriptor, sets its ownership bit, and then pulses a poll request. The engine walks the ring from its current position. For every descriptor it owns, it reads the buffer one word at a time and sends the bytes out in order. It then hands the descriptor back by rewriting only its status word with the ownership bit cleared.

The ring has no length register. A descriptor that carries the end-of-ring flag sends the engine back to the ring base; any other descriptor moves it forward by 16 bytes. When the engine meets a descriptor it does not own, it stops and waits for the next poll. Each completion raises a sticky interrupt status bit: a good frame sets the transmit-OK bit, and a bad length or a bus error sets the transmit-error bit. Software clears these bits by writing ones to them.

Top module: `txdesc_poll_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, irq_status is zero and both mem_req and tx_tvalid are low.
- R2: A write to register select 2 starts the engine only when bit 6 of the written data is 1 and the enable bit (select 3, bit 0) is 1. A write with bit 6 clear, or any write while the engine is disabled, issues no memory request. A poll written while disabled is not remembered.
- R3: The engine reads the status word at descriptor offset 0 and the buffer address words at offsets 8 and 12. It never reads or writes the word at offset 4. Every memory address it issues is word aligned.
- R4: The stream carries exactly the number of bytes given in status bits 12:0. Bytes leave in ascending address order, and within each word the least significant byte goes first. tx_tlast is high on the final byte only when status bit 28 is 1.
- R5: While tx_tvalid is high and tx_tready is low, tx_tvalid, tx_tdata and tx_tlast hold their values.
- R6: After each processed descriptor, exactly one memory write goes to that descriptor's offset 0. The written value is the fetched status word with bit 31 cleared and every other bit unchanged.
- R7: irq_status bit 2 is set when a descriptor completes without error. irq_status bits stay set until a write to select 4 has a 1 in the same bit position; a 0 leaves them unchanged.
- R8: After the status writeback, the next descriptor is at the current one plus 16 bytes. If status bit 30 was 1, the next descriptor is at the ring base instead.
- R9: A fetched status word with bit 31 equal to 0 makes the engine idle after that single read: no bytes, no write, no interrupt bit, and no further request until a new poll.
- R10: A length of 0 or a length above MAX_LEN (1536 by default) sends no bytes. It still writes the status back with bit 31 cleared, advances the ring, and sets irq_status bit 3 instead of bit 2.
- R11: An error response to any memory access sets irq_status bit 3 and leaves the engine idle, with no writeback and no ring advance. The next poll retries the same descriptor from its start.
- R12: The ring base comes from select 0 (address bits 31:8; data bits 7:0 are ignored) and select 1 (bits 63:32). Writing either register moves the ring position to the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0 base low, 1 base high, 2 poll, 3 enable, 4 interrupt clear |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request accepted or completed |
| mem_err | input | 1 | Error response, qualified by mem_ack |
| tx_tdata | output | 8 | Frame byte |
| tx_tvalid | output | 1 | Byte valid |
| tx_tready | input | 1 | Sink accepts byte |
| tx_tlast | output | 1 | Final byte of a frame |
| irq_status | output | IRQ_W | Sticky interrupt status, bit 2 OK, bit 3 error |

## Verification
The properties rely on the memory side answering each request with a single mem_ack. mem_err is taken to matter only together with that mem_ack. The bench memory model meets this by acknowledging in the same cycle as the request. It raises an error only on one chosen address, and only during the R11 test. The ring base is rewritten only while the engine is idle, because the pointer reload is not ordered against a writeback in flight. The bench writes the base only once, before the first poll. Back-pressure on tx_tready follows a fixed pattern that stalls one cycle in three during selected frames, so the hold properties are exercised.

// File: rtl/txp_pkg.sv
// Shared constants and state encoding for the transmit descriptor ring engine.
// Assumes a fixed four-word descriptor with ownership in the top status bit.
package txp_pkg;
    localparam int OWN_BIT    = 31;
    localparam int EOR_BIT    = 30;
    localparam int LS_BIT     = 28;
    localparam int LEN_W      = 13;
    localparam int DESC_BYTES = 16;
    localparam int POLL_BIT   = 6;
    localparam int IRQ_OK     = 2;
    localparam int IRQ_ERR    = 3;

    localparam logic [2:0] SEL_BASE_LO = 3'd0;
    localparam logic [2:0] SEL_BASE_HI = 3'd1;
    localparam logic [2:0] SEL_POLL    = 3'd2;
    localparam logic [2:0] SEL_CTRL    = 3'd3;
    localparam logic [2:0] SEL_IRQ     = 3'd4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_STAT, ST_ALO, ST_AHI, ST_DATA, ST_SEND, ST_WB
    } core_st_e;
endpackage

// File: rtl/txp_lane.sv
// Word-to-byte lane: holds one fetched buffer word and hands out its bytes
// least significant first. Assumes load and pop never occur together.
module txp_lane (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_word,
    input  logic [2:0]  load_cnt,
    input  logic        pop,
    output logic [7:0]  cur_byte,
    output logic [2:0]  lane_cnt
);
    logic [31:0] word_q;
    logic [2:0]  cnt_q;

    // Capture a word or shift the next byte into place.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            word_q <= load_word;
            cnt_q  <= load_cnt;
        end else if (pop) begin
            word_q <= {8'h00, word_q[31:8]};
            cnt_q  <= cnt_q - 3'd1;
        end
    end

    assign cur_byte = word_q[7:0];
    assign lane_cnt = cnt_q;
endmodule

// File: rtl/txp_regs.sv
// Register file: ring base, enable, one-shot poll latch and sticky interrupt
// bits. Assumes the base is rewritten only while the engine is idle.
module txp_regs
    import txp_pkg::*;
#(
    parameter int AW    = 64,
    parameter int IRQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [2:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    input  logic             ev_ok,
    input  logic             ev_err,
    input  logic             take_poll,
    output logic [AW-1:0]    base,
    output logic             base_load,
    output logic             poll_pend,
    output logic [IRQ_W-1:0] irq_status
);
    logic [63:0]      base_q;
    logic             en_q;
    logic             pend_q;
    logic             load_q;
    logic [IRQ_W-1:0] irq_q;
    logic             poll_set;
    logic             dis_wr;
    logic [IRQ_W-1:0] clr_mask;
    logic [IRQ_W-1:0] set_mask;

    // Decode write side effects for this cycle.
    always_comb begin
        poll_set = reg_we && (reg_sel == SEL_POLL) && reg_wdata[POLL_BIT] && en_q;
        dis_wr   = reg_we && (reg_sel == SEL_CTRL) && !reg_wdata[0];
        clr_mask = (reg_we && (reg_sel == SEL_IRQ)) ? reg_wdata[IRQ_W-1:0] : '0;
        set_mask = '0;
        set_mask[IRQ_OK]  = ev_ok;
        set_mask[IRQ_ERR] = ev_err;
    end

    // Hold configuration, poll latch and interrupt status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
            load_q <= 1'b0;
            irq_q  <= '0;
        end else begin
            load_q <= 1'b0;
            if (reg_we && reg_sel == SEL_BASE_LO) begin
                base_q[31:0] <= {reg_wdata[31:8], 8'h00};
                load_q       <= 1'b1;
            end
            if (reg_we && reg_sel == SEL_BASE_HI) begin
                base_q[63:32] <= reg_wdata;
                load_q        <= 1'b1;
            end
            if (reg_we && reg_sel == SEL_CTRL) en_q <= reg_wdata[0];
            if (dis_wr) pend_q <= 1'b0;
            else        pend_q <= (pend_q && !take_poll) || poll_set;
            irq_q <= (irq_q & ~clr_mask) | set_mask;
        end
    end

    assign base       = base_q[AW-1:0];
    assign base_load  = load_q;
    assign poll_pend  = pend_q;
    assign irq_status = irq_q;
endmodule

// File: rtl/txp_core.sv
// Descriptor walker: fetches status and buffer address, streams the buffer
// through the byte lane, writes the status back and advances the ring.
// Assumes one mem_ack per request, with mem_err qualified by mem_ack.
module txp_core
    import txp_pkg::*;
#(
    parameter int AW      = 64,
    parameter int MAX_LEN = 1536
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          poll_pend,
    output logic          take_poll,
    input  logic [AW-1:0] base,
    input  logic          base_load,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          mem_ack,
    input  logic          mem_err,
    output logic          lane_load,
    output logic [2:0]    lane_load_cnt,
    output logic          lane_pop,
    input  logic [7:0]    lane_byte,
    input  logic [2:0]    lane_cnt,
    output logic [7:0]    tx_tdata,
    output logic          tx_tvalid,
    input  logic          tx_tready,
    output logic          tx_tlast,
    output logic          ev_ok,
    output logic          ev_err
);
    core_st_e         st_q;
    logic [AW-1:0]    cur_q;
    logic [AW-1:0]    buf_q;
    logic [31:0]      stat_q;
    logic [LEN_W-1:0] remain_q;
    logic             bad_q;
    logic [LEN_W-1:0] rd_len;
    logic             ok_ack;
    logic             err_ack;
    logic [63:0]      buf_wide;

    assign rd_len   = mem_rdata[LEN_W-1:0];
    assign ok_ack   = mem_req && mem_ack && !mem_err;
    assign err_ack  = mem_req && mem_ack && mem_err;
    assign buf_wide = {mem_rdata, buf_q[31:0]};

    // Drive the memory request for the current phase.
    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_addr = cur_q;
        unique case (st_q)
            ST_STAT: mem_req = 1'b1;
            ST_ALO: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'(8);
            end
            ST_AHI: begin
                mem_req  = 1'b1;
                mem_addr = cur_q + AW'(12);
            end
            ST_DATA: begin
                mem_req  = 1'b1;
                mem_addr = {buf_q[AW-1:2], 2'b00};
            end
            ST_WB: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_wdata     = {1'b0, stat_q[30:0]};
    assign take_poll     = (st_q == ST_IDLE) && poll_pend;
    assign tx_tvalid     = (st_q == ST_SEND);
    assign tx_tdata      = lane_byte;
    assign tx_tlast      = (st_q == ST_SEND) && (remain_q == LEN_W'(1)) && stat_q[LS_BIT];
    assign lane_pop      = (st_q == ST_SEND) && tx_tready;
    assign lane_load     = (st_q == ST_DATA) && ok_ack;
    assign lane_load_cnt = (remain_q >= LEN_W'(4)) ? 3'd4 : remain_q[2:0];
    assign ev_ok         = (st_q == ST_WB) && ok_ack && !bad_q;
    assign ev_err        = err_ack || ((st_q == ST_WB) && ok_ack && bad_q);

    // Sequence one descriptor after another until an unowned one appears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= ST_IDLE;
            cur_q    <= '0;
            buf_q    <= '0;
            stat_q   <= '0;
            remain_q <= '0;
            bad_q    <= 1'b0;
        end else begin
            if (err_ack) st_q <= ST_IDLE;
            unique case (st_q)
                ST_IDLE: if (poll_pend) st_q <= ST_STAT;
                ST_STAT: if (ok_ack) begin
                    stat_q   <= mem_rdata;
                    remain_q <= rd_len;
                    if (!mem_rdata[OWN_BIT]) begin
                        st_q <= ST_IDLE;
                    end else if (rd_len == '0 || int'(rd_len) > MAX_LEN) begin
                        bad_q <= 1'b1;
                        st_q  <= ST_WB;
                    end else begin
                        bad_q <= 1'b0;
                        st_q  <= ST_ALO;
                    end
                end
                ST_ALO: if (ok_ack) begin
                    buf_q <= AW'(mem_rdata);
                    st_q  <= ST_AHI;
                end
                ST_AHI: if (ok_ack) begin
                    buf_q <= buf_wide[AW-1:0];
                    st_q  <= ST_DATA;
                end
                ST_DATA: if (ok_ack) st_q <= ST_SEND;
                ST_SEND: if (tx_tready) begin
                    remain_q <= remain_q - LEN_W'(1);
                    if (remain_q == LEN_W'(1)) begin
                        st_q <= ST_WB;
                    end else if (lane_cnt == 3'd1) begin
                        buf_q <= buf_q + AW'(4);
                        st_q  <= ST_DATA;
                    end
                end
                ST_WB: if (ok_ack) st_q <= ST_STAT;
                default: st_q <= ST_IDLE;
            endcase
            if (base_load) begin
                cur_q <= base;
            end else if (st_q == ST_WB && ok_ack) begin
                cur_q <= stat_q[EOR_BIT] ? base : cur_q + AW'(DESC_BYTES);
            end
        end
    end
endmodule

// File: rtl/txdesc_poll_engine.sv
// Top level of the transmit descriptor ring engine: register file, descriptor
// walker and byte lane. Assumes ADDR_W between 33 and 64 and IRQ_W above 3.
module txdesc_poll_engine
    import txp_pkg::*;
#(
    parameter int ADDR_W  = 64,
    parameter int MAX_LEN = 1536,
    parameter int IRQ_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err,
    output logic [7:0]        tx_tdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic              tx_tlast,
    output logic [IRQ_W-1:0]  irq_status
);
    logic [ADDR_W-1:0] base;
    logic              base_load;
    logic              poll_pend;
    logic              take_poll;
    logic              ev_ok;
    logic              ev_err;
    logic              lane_load;
    logic [2:0]        lane_load_cnt;
    logic              lane_pop;
    logic [7:0]        lane_byte;
    logic [2:0]        lane_cnt;

    txp_regs #(.AW(ADDR_W), .IRQ_W(IRQ_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ev_ok(ev_ok), .ev_err(ev_err),
        .take_poll(take_poll), .base(base), .base_load(base_load),
        .poll_pend(poll_pend), .irq_status(irq_status)
    );

    txp_core #(.AW(ADDR_W), .MAX_LEN(MAX_LEN)) u_core (
        .clk(clk), .rst_n(rst_n), .poll_pend(poll_pend), .take_poll(take_poll),
        .base(base), .base_load(base_load),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err), .lane_load(lane_load), .lane_load_cnt(lane_load_cnt),
        .lane_pop(lane_pop), .lane_byte(lane_byte), .lane_cnt(lane_cnt),
        .tx_tdata(tx_tdata), .tx_tvalid(tx_tvalid), .tx_tready(tx_tready),
        .tx_tlast(tx_tlast), .ev_ok(ev_ok), .ev_err(ev_err)
    );

    txp_lane u_lane (
        .clk(clk), .rst_n(rst_n), .load(lane_load), .load_word(mem_rdata),
        .load_cnt(lane_load_cnt), .pop(lane_pop), .cur_byte(lane_byte),
        .lane_cnt(lane_cnt)
    );
endmodule

// File: rtl/txp_checker.sv
// Port-level properties of the transmit descriptor ring engine, bound to the top.
// Assumes a single mem_ack per request.
module txp_checker
    import txp_pkg::*;
#(
    parameter int AW    = 64,
    parameter int IRQ_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_sel,
    input logic [31:0]      reg_wdata,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic [7:0]       tx_tdata,
    input logic             tx_tvalid,
    input logic             tx_tready,
    input logic             tx_tlast,
    input logic [IRQ_W-1:0] irq_status
);
    // R1: reset leaves the memory side and the stream quiet
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!mem_req && !tx_tvalid));

    // R3: addresses are word aligned
    p_word_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // R3: a pending request keeps its address and direction
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: the stream never overlaps a memory access
    p_stream_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tvalid |-> !mem_req);

    // R4: an accepted final byte ends the stream for that frame
    p_last_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tvalid && tx_tready && tx_tlast) |=> !tx_tvalid);

    // R5: a stalled byte holds
    p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_tvalid && !tx_tready) |=>
            (tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast)));

    // R6: a writeback always returns ownership
    p_wb_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R7: the OK bit persists until cleared by a one
    p_ok_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[IRQ_OK] && !(reg_we && reg_sel == SEL_IRQ && reg_wdata[IRQ_OK]))
            |=> irq_status[IRQ_OK]);

    // R11: the error bit persists until cleared by a one
    p_err_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status[IRQ_ERR] && !(reg_we && reg_sel == SEL_IRQ && reg_wdata[IRQ_ERR]))
            |=> irq_status[IRQ_ERR]);
endmodule

bind txdesc_poll_engine txp_checker #(.AW(ADDR_W), .IRQ_W(IRQ_W)) u_chk (.*);

// File: tb/txdesc_poll_engine_bench.sv
// Self-checking bench: memory model, stream monitor, vector table and directed tests.
module txdesc_poll_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [2:0]  reg_sel;
    logic [31:0] reg_wdata;
    logic        mem_req, mem_we, mem_ack, mem_err;
    logic [63:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [7:0]  tx_tdata;
    logic        tx_tvalid, tx_tready, tx_tlast;
    logic [15:0] irq_status;

    always #5 clk = ~clk;

    txdesc_poll_engine u_txdesc_poll_engine (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_ack(mem_ack), .mem_err(mem_err), .tx_tdata(tx_tdata),
        .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tlast(tx_tlast),
        .irq_status(irq_status)
    );

    // Memory model: zeroed descriptor area below 0x800, patterned buffers above.
    logic [31:0] mem [4096];
    logic        tb_we;
    logic [11:0] tb_idx;
    logic [31:0] tb_dat;
    logic        err_en;
    logic [63:0] err_addr;
    logic        bp_en;
    int          cyc = 0;

    function automatic logic [31:0] pat(int i);
        return (32'(i) * 32'h0101_0101) ^ 32'h5A3C_96E1 ^ (32'(i) << 13);
    endfunction

    function automatic logic [7:0] exp_byte(int a);
        logic [31:0] w;
        w = pat(a >> 2);
        return 8'(w >> (8 * (a % 4)));
    endfunction

    assign mem_ack   = mem_req;
    assign mem_err   = mem_req && err_en && (mem_addr == err_addr);
    assign mem_rdata = mem[mem_addr[13:2]];
    assign tx_tready = !bp_en || (cyc % 3 != 0);

    always @(negedge clk) cyc++;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= (i < 512) ? 32'h0 : pat(i);
        end else begin
            if (mem_req && mem_we && !mem_err) mem[mem_addr[13:2]] <= mem_wdata;
            if (tb_we) mem[tb_idx] <= tb_dat;
        end
    end

    // Monitor of memory traffic and stream bytes.
    int          n_rd = 0, n_wr = 0, n_vlan = 0, n_cap = 0, n_last = 0, n_mis = 0;
    int          last_idx = -1;
    logic [63:0] last_wr_addr = '0;
    int          cap_start;
    int          exp_buf;

    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_ack) begin
                if (mem_we) begin
                    n_wr++;
                    last_wr_addr = mem_addr;
                end else begin
                    n_rd++;
                end
                if (mem_addr < 64'h800 && mem_addr[3:0] == 4'h4) n_vlan++;
            end
            if (tx_tvalid && tx_tready) begin
                if (tx_tdata != exp_byte(exp_buf + n_cap - cap_start)) n_mis++;
                if (tx_tlast) begin
                    n_last++;
                    last_idx = n_cap;
                end
                n_cap++;
            end
        end
    end

    int checks = 0;
    int fails  = 0;

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic [2:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic poke(int idx, logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_idx = 12'(idx); tb_dat = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic int sidx(int slot);
        return (32'h100 >> 2) + slot * 4;
    endfunction

    task automatic put_desc(int slot, logic [31:0] st, int bufa);
        poke(sidx(slot), st);
        poke(sidx(slot) + 1, 32'hDEAD_BEEF);
        poke(sidx(slot) + 2, 32'(bufa));
        poke(sidx(slot) + 3, 32'h0);
    endtask

    task automatic wait_irq();
        int t = 0;
        while (irq_status == 16'h0 && t < 20000) begin
            @(negedge clk);
            t++;
        end
        repeat (20) @(negedge clk);
    endtask

    // Vector: [12:0] length, [13] last-segment, [14] end-of-ring, [15] expect OK, [16] back-pressure
    localparam logic [31:0] VEC [8] = '{
        32'h0000A03C, 32'h0001A03D, 32'h0001A600, 32'h00002601,
        32'h00008064, 32'h0001E040, 32'h0000A03E, 32'h00002000
    };

    int slot;

    task automatic run_vec(int v, logic [31:0] vec);
        int len, bufa, c0, l0, w0, m0, nxt;
        logic ls, eor, ok;
        logic [31:0] st;
        len  = int'(vec[12:0]);
        ls   = vec[13];
        eor  = vec[14];
        ok   = vec[15];
        bufa = 32'h800 + v * 32'h700;
        st   = 32'h8000_0000 | (32'(eor) << 30) | 32'h2000_0000 | (32'(ls) << 28)
             | 32'h0001_0000 | 32'(len);
        put_desc(slot, st, bufa);
        nxt = eor ? 0 : slot + 1;
        if (nxt != slot) poke(sidx(nxt), 32'h0);
        bp_en = vec[16];
        reg_wr(SEL_IRQ_C, 32'hFFFF);
        c0 = n_cap; l0 = n_last; w0 = n_wr; m0 = n_mis;
        cap_start = n_cap; exp_buf = bufa;
        reg_wr(3'd2, 32'h40);
        wait_irq();
        chk($sformatf("R4 R10 vec%0d byte count", v), n_cap - c0, ok ? len : 0);
        chk($sformatf("R4 vec%0d byte order", v), n_mis - m0, 0);
        chk($sformatf("R4 vec%0d tlast count", v), n_last - l0, (ok && ls) ? 1 : 0);
        if (ok && ls) chk($sformatf("R4 vec%0d tlast position", v), last_idx, n_cap - 1);
        chk($sformatf("R6 vec%0d status writeback", v), mem[sidx(slot)], st & 32'h7FFF_FFFF);
        chk($sformatf("R6 vec%0d one write", v), n_wr - w0, 1);
        chk($sformatf("R8 R12 vec%0d write address", v), last_wr_addr, 64'h100 + slot * 16);
        chk($sformatf("R7 R10 vec%0d irq", v), irq_status, ok ? 16'h4 : 16'h8);
        slot = nxt;
    endtask

    localparam logic [2:0] SEL_IRQ_C = 3'd4;

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int r0, c0, w0;
        logic [31:0] st;
        reg_we = 0; reg_sel = 0; reg_wdata = 0;
        tb_we = 0; tb_idx = 0; tb_dat = 0;
        err_en = 0; err_addr = 0; bp_en = 0;
        cap_start = 0; exp_buf = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", irq_status, 0);
        chk("R1 tvalid after reset", tx_tvalid, 0);
        chk("R1 mem_req after reset", mem_req, 0);

        // R12: low byte of the base is dropped, so the ring sits at 0x100
        reg_wr(3'd0, 32'h0000_01A5);
        reg_wr(3'd1, 32'h0);
        reg_wr(3'd3, 32'h1);
        slot = 0;
        for (int v = 0; v < 8; v++) run_vec(v, VEC[v]);

        // R2: poll gating by bit 6 and by enable
        bp_en = 1'b0;
        st = 32'hB000_003C;
        put_desc(slot, st, 32'h800);
        poke(sidx(slot + 1), 32'h0);
        r0 = n_rd;
        reg_wr(3'd2, 32'h01);
        repeat (20) @(negedge clk);
        chk("R2 poll without bit 6", n_rd - r0, 0);
        reg_wr(3'd3, 32'h0);
        reg_wr(3'd2, 32'h40);
        reg_wr(3'd3, 32'h1);
        repeat (20) @(negedge clk);
        chk("R2 poll while disabled not kept", n_rd - r0, 0);
        reg_wr(SEL_IRQ_C, 32'hFFFF);
        cap_start = n_cap; exp_buf = 32'h800;
        reg_wr(3'd2, 32'h40);
        wait_irq();
        chk("R2 valid poll runs", irq_status, 16'h4);
        slot = slot + 1;

        // R9: unowned descriptor stops after one read
        reg_wr(SEL_IRQ_C, 32'hFFFF);
        r0 = n_rd; c0 = n_cap; w0 = n_wr;
        reg_wr(3'd2, 32'h40);
        repeat (30) @(negedge clk);
        chk("R9 single read", n_rd - r0, 1);
        chk("R9 no bytes", n_cap - c0, 0);
        chk("R9 no write", n_wr - w0, 0);
        chk("R9 no irq", irq_status, 0);

        // R11: error on the second buffer word, then retry
        st = 32'hB000_0040;
        put_desc(slot, st, 32'h800);
        poke(sidx(slot + 1), 32'h0);
        err_addr = 64'h804; err_en = 1'b1;
        reg_wr(SEL_IRQ_C, 32'hFFFF);
        w0 = n_wr;
        cap_start = n_cap; exp_buf = 32'h800;
        reg_wr(3'd2, 32'h40);
        wait_irq();
        chk("R11 error bit", irq_status, 16'h8);
        chk("R11 descriptor still owned", mem[sidx(slot)], st);
        chk("R11 no writeback", n_wr - w0, 0);
        err_en = 1'b0;
        reg_wr(SEL_IRQ_C, 32'hFFFF);
        c0 = n_cap;
        cap_start = n_cap; exp_buf = 32'h800;
        reg_wr(3'd2, 32'h40);
        wait_irq();
        chk("R11 retry completes", irq_status, 16'h4);
        chk("R11 retry byte count", n_cap - c0, 64);
        chk("R11 retry writeback", mem[sidx(slot)], st & 32'h7FFF_FFFF);

        // R7: writing zero keeps the bit, writing one clears it
        reg_wr(SEL_IRQ_C, 32'h0);
        chk("R7 zero write keeps", irq_status, 16'h4);
        reg_wr(SEL_IRQ_C, 32'h4);
        chk("R7 one write clears", irq_status, 16'h0);

        chk("R3 tag word untouched", n_vlan, 0);
        chk("R4 no byte mismatch overall", n_mis, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule